// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the multi-cycle state save and restore that surround an interrupt handler in a small 16-bit segmented processor core. When a request is taken at an instruction boundary, it pushes the flag word, the code segment and the instruction pointer onto the stack. It clears the interrupt-enable and trap bits. It then reads the handler's IP and CS from a 1 KiB vector table at the bottom of memory. On a return request it pops IP, CS and flags in that order and restores the stack pointer.

Requests come from four places. Two are internal exception pulses, divide error and arithmetic overflow, with fixed type numbers. The third is a software interrupt pulse that carries its own 8-bit type. The fourth is a maskable external level that is answered with a one-cycle acknowledge, during which the type is taken from a type bus. The core supplies its current architectural registers. The sequencer works on a private copy and hands the final values back with a single write strobe. Memory is a 16-bit word port on byte addresses and returns read data in the same cycle.

Top module: `irqSequencer`

## Requirements
- R1: While reset is held and after it is released, busy, extAck, archWe, memWe and memRe are low, and newIp, newCs, newFlags and newSp read zero.
- R2: A request is only taken in a cycle where insnBoundary is high and no sequence is running. A divide, overflow or software pulse that arrives without a boundary starts nothing, and it is serviced at the next boundary with its own type.
- R3: Entry writes the original flag word at byte address SS*16+SP-2, then CS at SS*16+SP-4, then IP at SS*16+SP-6. SP is decremented by 2 before each write, so the final SP is the entry SP minus 6.
- R4: After entry, the new IP is the word at byte address type*4 and the new CS is the word at type*4+2. The new flags equal the entry flags with bit 9 (interrupt enable) and bit 8 (trap) cleared.
- R5: When iretReq is high at a boundary, the return sequence reads IP from SS*16+SP, CS from SS*16+SP+2 and flags from SS*16+SP+4. The final SP is the entry SP plus 6.
- R6: A divErr pulse runs entry with type 0, and an ovfErr pulse runs it with type 4. Neither produces extAck.
- R7: A swReq pulse runs entry with the type given on swType in that cycle. Types 0 through 255 are all usable, including type 255, whose table entry sits at 0x3FC.
- R8: A taken external request gives extAck for exactly one cycle, in the cycle after the boundary. The type is the value on extType during that cycle.
- R9: While bit 9 of curFlags is 0, extReq is ignored: no extAck and no sequence follow.
- R10: When several sources are pending at one boundary, the order is divide error, then overflow, then software, then external. The sources that lose are serviced one per later boundary in that same order.
- R11: busy is high for exactly 5 cycles of an entry (three pushes and two vector reads) and 3 cycles of a return. archWe is a one-cycle pulse in the cycle after busy falls, and it carries the final register values. For an external request, extAck precedes the first busy cycle directly.
- R12: A software pulse that arrives while busy is high is kept, and it is serviced at the first boundary after the current sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| insnBoundary | input | 1 | High in a cycle between two instructions |
| iretReq | input | 1 | Return-from-interrupt request, sampled at a boundary |
| extReq | input | 1 | Maskable external request level |
| extType | input | 8 | Type number presented while extAck is high |
| extAck | output | 1 | One-cycle acknowledge of an external request |
| divErr | input | 1 | Divide-error exception pulse |
| ovfErr | input | 1 | Overflow exception pulse |
| swReq | input | 1 | Software interrupt pulse |
| swType | input | 8 | Type number carried with swReq |
| curFlags | input | 16 | Current flag word |
| curCs | input | 16 | Current code segment |
| curIp | input | 16 | Address of the next instruction |
| curSp | input | 16 | Current stack pointer |
| curSs | input | 16 | Current stack segment |
| memAddr | output | 20 | Byte address of the memory access |
| memWe | output | 1 | Word write strobe |
| memRe | output | 1 | Word read strobe |
| memWData | output | 16 | Write data |
| memRData | input | 16 | Read data, valid in the same cycle as memRe |
| busy | output | 1 | Push, pop or vector read in progress |
| archWe | output | 1 | One-cycle strobe to load the outputs below |
| newFlags | output | 16 | Flag word to commit |
| newCs | output | 16 | Code segment to commit |
| newIp | output | 16 | Instruction pointer to commit |
| newSp | output | 16 | Stack pointer to commit |

## Verification
The assertions rely on the core to keep insnBoundary low while a sequence is running. They also rely on extReq and the interrupt-enable bit being steady across the boundary cycle, so that an acknowledge can always be traced back to an unmasked request in the previous cycle. The bench respects both. It raises insnBoundary for a single cycle and then holds it low until archWe has been seen. It changes curFlags only on the falling edge that comes before a boundary. Exception and software pulses last exactly one cycle. The memory model answers reads in the same cycle, and every stack address stays inside the modelled region, well above the vector table.

// File: rtl/irqSeqPkg.sv
package irqSeqPkg;
  localparam int TYPE_W = 8;
  localparam logic [TYPE_W-1:0] DIV_TYPE = TYPE_W'(0);
  localparam logic [TYPE_W-1:0] OVF_TYPE = TYPE_W'(4);

  typedef enum logic [3:0] {
    S_IDLE, S_ACK, S_PUSHF, S_PUSHCS, S_PUSHIP, S_VECLO, S_VECHI,
    S_POPIP, S_POPCS, S_POPF, S_COMMIT
  } seqState_t;

  typedef enum logic [1:0] { W_FLAGS, W_CS, W_IP } wordSel_t;

  typedef struct packed {
    logic              capture;
    logic              loadType;
    logic [TYPE_W-1:0] typeVal;
    logic              push;
    logic              pop;
    wordSel_t          sel;
    logic              vecLo;
    logic              vecHi;
    logic              maskFlags;
  } seqStrobe_t;
endpackage

// File: rtl/irqSeqCtrl.sv
module irqSeqCtrl
  import irqSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              insnBoundary,
  input  logic              iretReq,
  input  logic              extReq,
  input  logic              ifFlag,
  input  logic [TYPE_W-1:0] extType,
  input  logic              divErr,
  input  logic              ovfErr,
  input  logic              swReq,
  input  logic [TYPE_W-1:0] swType,
  output seqStrobe_t        strobe,
  output logic              extAck,
  output logic              busy,
  output logic              archWe
);
  seqState_t state, nextState;
  logic pendDiv, pendOvf, pendSw;
  logic [TYPE_W-1:0] pendSwType;

  logic effDiv, effOvf, effSw, accept;
  logic takeIret, takeDiv, takeOvf, takeSw, takeExt;
  logic [TYPE_W-1:0] effSwType;

  assign effDiv    = pendDiv | divErr;
  assign effOvf    = pendOvf | ovfErr;
  assign effSw     = pendSw | swReq;
  assign effSwType = swReq ? swType : pendSwType;
  assign accept    = (state == S_IDLE) && insnBoundary;

  // fixed chain: return, divide, overflow, software, external
  assign takeIret = accept && iretReq;
  assign takeDiv  = accept && !iretReq && effDiv;
  assign takeOvf  = accept && !iretReq && !effDiv && effOvf;
  assign takeSw   = accept && !iretReq && !effDiv && !effOvf && effSw;
  assign takeExt  = accept && !iretReq && !effDiv && !effOvf && !effSw
                    && extReq && ifFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      pendDiv    <= 1'b0;
      pendOvf    <= 1'b0;
      pendSw     <= 1'b0;
      pendSwType <= '0;
    end else begin
      state   <= nextState;
      pendDiv <= effDiv & ~takeDiv;
      pendOvf <= effOvf & ~takeOvf;
      pendSw  <= effSw & ~takeSw;
      if (swReq) pendSwType <= swType;
    end
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    extAck    = 1'b0;
    archWe    = 1'b0;
    case (state)
      S_IDLE: begin
        if (takeIret) begin
          strobe.capture = 1'b1;
          nextState      = S_POPIP;
        end else if (takeExt) begin
          strobe.capture = 1'b1;
          nextState      = S_ACK;
        end else if (takeDiv || takeOvf || takeSw) begin
          strobe.capture  = 1'b1;
          strobe.loadType = 1'b1;
          strobe.typeVal  = takeDiv ? DIV_TYPE : (takeOvf ? OVF_TYPE : effSwType);
          nextState       = S_PUSHF;
        end
      end
      S_ACK: begin
        extAck          = 1'b1;
        strobe.loadType = 1'b1;
        strobe.typeVal  = extType;
        nextState       = S_PUSHF;
      end
      S_PUSHF: begin
        strobe.push      = 1'b1;
        strobe.sel       = W_FLAGS;
        strobe.maskFlags = 1'b1;
        nextState        = S_PUSHCS;
      end
      S_PUSHCS: begin
        strobe.push = 1'b1;
        strobe.sel  = W_CS;
        nextState   = S_PUSHIP;
      end
      S_PUSHIP: begin
        strobe.push = 1'b1;
        strobe.sel  = W_IP;
        nextState   = S_VECLO;
      end
      S_VECLO: begin
        strobe.vecLo = 1'b1;
        nextState    = S_VECHI;
      end
      S_VECHI: begin
        strobe.vecHi = 1'b1;
        nextState    = S_COMMIT;
      end
      S_POPIP: begin
        strobe.pop = 1'b1;
        strobe.sel = W_IP;
        nextState  = S_POPCS;
      end
      S_POPCS: begin
        strobe.pop = 1'b1;
        strobe.sel = W_CS;
        nextState  = S_POPF;
      end
      S_POPF: begin
        strobe.pop = 1'b1;
        strobe.sel = W_FLAGS;
        nextState  = S_COMMIT;
      end
      S_COMMIT: begin
        archWe    = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = state inside {S_PUSHF, S_PUSHCS, S_PUSHIP, S_VECLO, S_VECHI,
                              S_POPIP, S_POPCS, S_POPF};
endmodule

// File: rtl/irqSeqPath.sv
module irqSeqPath
  import irqSeqPkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int IF_BIT    = 9,
  parameter int TF_BIT    = 8,
  parameter int SEG_SHIFT = 4,
  parameter int VEC_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] curFlags,
  input  logic [DATA_W-1:0] curCs,
  input  logic [DATA_W-1:0] curIp,
  input  logic [DATA_W-1:0] curSp,
  input  logic [DATA_W-1:0] curSs,
  input  logic [DATA_W-1:0] memRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic              memWe,
  output logic              memRe,
  output logic [DATA_W-1:0] newFlags,
  output logic [DATA_W-1:0] newCs,
  output logic [DATA_W-1:0] newIp,
  output logic [DATA_W-1:0] newSp
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam logic [DATA_W-1:0] STEP = DATA_W'(WORD_BYTES);
  localparam logic [DATA_W-1:0] CLR_MASK =
    ~((DATA_W'(1) << IF_BIT) | (DATA_W'(1) << TF_BIT));

  logic [DATA_W-1:0] flagsR, csR, ipR, spR, ssR;
  logic [TYPE_W-1:0] typeR;
  logic [DATA_W-1:0] spDown, stackOff;
  logic [ADDR_W-1:0] segBase, stackAddr, vecBase, vecAddr;

  assign spDown    = spR - STEP;
  assign stackOff  = strobe.push ? spDown : spR;
  assign segBase   = ADDR_W'(ssR) << SEG_SHIFT;
  assign stackAddr = segBase + ADDR_W'(stackOff);
  assign vecBase   = ADDR_W'(typeR) << VEC_SHIFT;
  assign vecAddr   = strobe.vecHi ? vecBase + ADDR_W'(WORD_BYTES) : vecBase;
  assign memAddr   = (strobe.vecLo || strobe.vecHi) ? vecAddr : stackAddr;
  assign memWe     = strobe.push;
  assign memRe     = strobe.pop | strobe.vecLo | strobe.vecHi;

  always_comb begin
    case (strobe.sel)
      W_FLAGS: memWData = flagsR;
      W_CS:    memWData = csR;
      default: memWData = ipR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsR <= '0;
      csR    <= '0;
      ipR    <= '0;
      spR    <= '0;
      ssR    <= '0;
      typeR  <= '0;
    end else begin
      if (strobe.capture) begin
        flagsR <= curFlags;
        csR    <= curCs;
        ipR    <= curIp;
        spR    <= curSp;
        ssR    <= curSs;
      end
      if (strobe.loadType) typeR <= strobe.typeVal;
      if (strobe.push) begin
        spR <= spDown;
        if (strobe.maskFlags) flagsR <= flagsR & CLR_MASK;
      end
      if (strobe.pop) begin
        spR <= spR + STEP;
        case (strobe.sel)
          W_FLAGS: flagsR <= memRData;
          W_CS:    csR    <= memRData;
          default: ipR    <= memRData;
        endcase
      end
      if (strobe.vecLo) ipR <= memRData;
      if (strobe.vecHi) csR <= memRData;
    end
  end

  assign newFlags = flagsR;
  assign newCs    = csR;
  assign newIp    = ipR;
  assign newSp    = spR;
endmodule

// File: rtl/irqSequencer.sv
module irqSequencer
  import irqSeqPkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int IF_BIT    = 9,
  parameter int TF_BIT    = 8,
  parameter int SEG_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insnBoundary,
  input  logic              iretReq,
  input  logic              extReq,
  input  logic [TYPE_W-1:0] extType,
  output logic              extAck,
  input  logic              divErr,
  input  logic              ovfErr,
  input  logic              swReq,
  input  logic [TYPE_W-1:0] swType,
  input  logic [DATA_W-1:0] curFlags,
  input  logic [DATA_W-1:0] curCs,
  input  logic [DATA_W-1:0] curIp,
  input  logic [DATA_W-1:0] curSp,
  input  logic [DATA_W-1:0] curSs,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  output logic              busy,
  output logic              archWe,
  output logic [DATA_W-1:0] newFlags,
  output logic [DATA_W-1:0] newCs,
  output logic [DATA_W-1:0] newIp,
  output logic [DATA_W-1:0] newSp
);
  seqStrobe_t strobe;

  irqSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .insnBoundary(insnBoundary), .iretReq(iretReq),
    .extReq(extReq), .ifFlag(curFlags[IF_BIT]), .extType(extType),
    .divErr(divErr), .ovfErr(ovfErr), .swReq(swReq), .swType(swType),
    .strobe(strobe), .extAck(extAck), .busy(busy), .archWe(archWe)
  );

  irqSeqPath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IF_BIT(IF_BIT), .TF_BIT(TF_BIT),
    .SEG_SHIFT(SEG_SHIFT), .VEC_SHIFT(2)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .curFlags(curFlags), .curCs(curCs), .curIp(curIp), .curSp(curSp),
    .curSs(curSs), .memRData(memRData), .memAddr(memAddr),
    .memWData(memWData), .memWe(memWe), .memRe(memRe),
    .newFlags(newFlags), .newCs(newCs), .newIp(newIp), .newSp(newSp)
  );
endmodule

// File: rtl/irqSeqChecker.sv
module irqSeqChecker #(
  parameter int DATA_W = 16,
  parameter int IF_BIT = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              insnBoundary,
  input logic              extReq,
  input logic [DATA_W-1:0] curFlags,
  input logic              extAck,
  input logic              busy,
  input logic              archWe,
  input logic              memWe,
  input logic              memRe
);
  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    extAck |=> !extAck);

  // R9
  ack_unmasked_chk: assert property (@(posedge clk) disable iff (!rstN)
    extAck |-> $past(insnBoundary && extReq && curFlags[IF_BIT]));

  // R11
  ack_then_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    extAck |=> busy);

  // R11
  commit_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    archWe |-> (!busy && $past(busy)));

  // R3
  write_in_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (busy && !memRe));
endmodule

bind irqSequencer irqSeqChecker #(.DATA_W(DATA_W), .IF_BIT(IF_BIT)) u_chk (
  .clk(clk), .rstN(rstN), .insnBoundary(insnBoundary), .extReq(extReq),
  .curFlags(curFlags), .extAck(extAck), .busy(busy), .archWe(archWe),
  .memWe(memWe), .memRe(memRe)
);

// File: tb/irqSequencer_bench.sv
module irqSequencer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic insnBoundary = 0, iretReq = 0, extReq = 0, divErr = 0, ovfErr = 0, swReq = 0;
  logic [7:0] extType = 0, swType = 0;
  logic [15:0] curFlags = 0, curCs = 0, curIp = 0, curSp = 0, curSs = 16'h0100;
  logic [19:0] memAddr;
  logic memWe, memRe, extAck, busy, archWe;
  logic [15:0] memWData, memRData, newFlags, newCs, newIp, newSp;

  irqSequencer u_irqSequencer (
    .clk(clk), .rstN(rstN), .insnBoundary(insnBoundary), .iretReq(iretReq),
    .extReq(extReq), .extType(extType), .extAck(extAck), .divErr(divErr),
    .ovfErr(ovfErr), .swReq(swReq), .swType(swType), .curFlags(curFlags),
    .curCs(curCs), .curIp(curIp), .curSp(curSp), .curSs(curSs),
    .memAddr(memAddr), .memWe(memWe), .memRe(memRe), .memWData(memWData),
    .memRData(memRData), .busy(busy), .archWe(archWe), .newFlags(newFlags),
    .newCs(newCs), .newIp(newIp), .newSp(newSp)
  );

  logic [15:0] mem [0:4095];
  assign memRData = mem[memAddr[12:1]];
  always @(posedge clk) if (memWe) mem[memAddr[12:1]] <= memWData;

  int checks = 0, errors = 0;
  int busyCnt, ackCnt, ackAt, busyAt;
  logic done;
  logic [15:0] gotFlags, gotCs, gotIp, gotSp;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] stackWord(input logic [15:0] off);
    logic [19:0] a;
    a = 20'h01000 + 20'(off);
    return mem[a[12:1]];
  endfunction

  task automatic runSeq(input logic [15:0] fl, cs, ip, sp,
                        input logic dv, ov, sw, input logic [7:0] swT,
                        input logic ex, ir, midSw, input logic [7:0] midT);
    int n;
    @(negedge clk);
    curFlags = fl; curCs = cs; curIp = ip; curSp = sp;
    divErr = dv; ovfErr = ov; swReq = sw; swType = swT; extReq = ex; iretReq = ir;
    insnBoundary = 1;
    busyCnt = 0; ackCnt = 0; ackAt = -1; busyAt = -1; done = 0; n = 0;
    @(posedge clk);
    while (!done && n < 40) begin
      @(negedge clk);
      if (n == 0) begin
        insnBoundary = 0; divErr = 0; ovfErr = 0; swReq = 0; iretReq = 0;
      end
      if (midSw && n == 2) begin swReq = 1; swType = midT; end
      if (midSw && n == 3) swReq = 0;
      if (extAck) begin ackCnt++; ackAt = n; end
      if (busy) begin busyCnt++; if (busyAt < 0) busyAt = n; end
      if (archWe) begin
        done = 1; gotFlags = newFlags; gotCs = newCs; gotIp = newIp; gotSp = newSp;
      end
      n++;
    end
    extReq = 0;
    check(done, "R11 sequence completes", 32'(done), 1);
  endtask

  // src: 0 software, 1 external, 2 divide, 3 overflow; type is the expected one
  localparam logic [73:0] VECS [6] = '{
    {2'd0, 8'h21, 16'h0302, 16'h1234, 16'h0102, 16'h0200},
    {2'd1, 8'h08, 16'h0202, 16'h4000, 16'h0010, 16'h01F0},
    {2'd2, 8'h00, 16'h0ED5, 16'h5555, 16'hAAAA, 16'h0400},
    {2'd3, 8'h04, 16'h0100, 16'hFFFF, 16'hFFFE, 16'h0100},
    {2'd0, 8'hFF, 16'hFFFF, 16'h0000, 16'h0000, 16'h0300},
    {2'd1, 8'h01, 16'h0200, 16'h0ABC, 16'h0DEF, 16'h0010}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    for (int t = 0; t < 256; t++) begin
      mem[2*t]     = 16'hA000 | 16'(t);
      mem[2*t + 1] = 16'h3000 | 16'(t);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !extAck && !archWe && !memWe && !memRe, "R1 strobes low in reset",
          {busy, extAck, archWe, memWe, memRe}, 0);
    rstN = 1;
    @(negedge clk);
    check(!busy && !extAck && !archWe, "R1 strobes low after reset", {busy, extAck, archWe}, 0);
    check(newIp == 0 && newCs == 0 && newFlags == 0 && newSp == 0, "R1 outputs zero",
          {newIp, newCs}, 0);

    for (int k = 0; k < 6; k++) begin
      automatic logic [73:0] v = VECS[k];
      automatic logic [1:0] src = v[73:72];
      automatic logic [7:0] ty = v[71:64];
      automatic logic [15:0] fl = v[63:48], cs = v[47:32], ip = v[31:16], sp = v[15:0];
      if (src == 1) extType = ty;
      runSeq(fl, cs, ip, sp, src == 2, src == 3, src == 0, ty, src == 1, 0, 0, 0);
      // R3 stack contents and SP
      check(stackWord(sp - 16'd2) == fl, "R3 flags pushed", stackWord(sp - 16'd2), fl);
      check(stackWord(sp - 16'd4) == cs, "R3 cs pushed", stackWord(sp - 16'd4), cs);
      check(stackWord(sp - 16'd6) == ip, "R3 ip pushed", stackWord(sp - 16'd6), ip);
      check(gotSp == sp - 16'd6, "R3 sp after entry", gotSp, sp - 16'd6);
      // R4 R6 R7 R8 vector and flags
      check(gotIp == (16'hA000 | 16'(ty)), "R4 R6 R7 R8 vector ip", gotIp, 16'hA000 | 16'(ty));
      check(gotCs == (16'h3000 | 16'(ty)), "R4 vector cs", gotCs, 16'h3000 | 16'(ty));
      check(gotFlags == (fl & 16'hFCFF), "R4 IF TF cleared", gotFlags, fl & 16'hFCFF);
      check(busyCnt == 5, "R11 entry busy length", busyCnt, 5);
      if (src == 1) begin
        check(ackCnt == 1 && ackAt == 0, "R8 single ack after boundary", ackCnt, 1);
        check(busyAt == ackAt + 1, "R11 ack precedes busy", busyAt, ackAt + 1);
      end else begin
        check(ackCnt == 0, "R6 R7 no ack for internal or software", ackCnt, 0);
      end
      // R5 return
      runSeq(16'h0000, gotCs, gotIp + 16'd10, gotSp, 0, 0, 0, 0, 0, 1, 0, 0);
      check(gotIp == ip, "R5 ip restored", gotIp, ip);
      check(gotCs == cs, "R5 cs restored", gotCs, cs);
      check(gotFlags == fl, "R5 flags restored", gotFlags, fl);
      check(gotSp == sp, "R5 sp restored", gotSp, sp);
      check(busyCnt == 3 && ackCnt == 0, "R11 return busy length", busyCnt, 3);
    end

    // R9 masked external request
    begin
      int seen;
      seen = 0;
      @(negedge clk);
      curFlags = 16'h0000; extReq = 1; insnBoundary = 1;
      for (int n = 0; n < 8; n++) begin
        @(negedge clk);
        if (n == 3) insnBoundary = 0;
        if (extAck || busy || archWe) seen++;
      end
      extReq = 0;
      check(seen == 0, "R9 masked request ignored", seen, 0);
    end

    // R10 priority among simultaneous sources
    extType = 8'h77;
    runSeq(16'h0200, 16'h0001, 16'h0002, 16'h0500, 1, 1, 1, 8'h33, 1, 0, 0, 0);
    check(gotIp == 16'hA000 && ackCnt == 0, "R10 divide first", gotIp, 16'hA000);
    runSeq(16'h0200, 16'h0001, 16'h0002, 16'h0500, 0, 0, 0, 0, 1, 0, 0, 0);
    check(gotIp == 16'hA004 && ackCnt == 0, "R10 overflow second", gotIp, 16'hA004);
    runSeq(16'h0200, 16'h0001, 16'h0002, 16'h0500, 0, 0, 0, 0, 1, 0, 0, 0);
    check(gotIp == 16'hA033 && ackCnt == 0, "R10 software third", gotIp, 16'hA033);
    runSeq(16'h0200, 16'h0001, 16'h0002, 16'h0500, 0, 0, 0, 0, 1, 0, 0, 0);
    check(gotIp == 16'hA077 && ackCnt == 1, "R10 external last", gotIp, 16'hA077);

    // R2 pulse without boundary is held, not acted on
    begin
      int seen;
      seen = 0;
      @(negedge clk);
      swReq = 1; swType = 8'h44;
      @(negedge clk);
      swReq = 0;
      for (int n = 0; n < 6; n++) begin
        @(negedge clk);
        if (busy || archWe || memWe) seen++;
      end
      check(seen == 0, "R2 no start without boundary", seen, 0);
    end
    runSeq(16'h0000, 16'h0001, 16'h0002, 16'h0600, 0, 0, 0, 0, 0, 0, 0, 0);
    check(gotIp == 16'hA044, "R2 held pulse serviced at boundary", gotIp, 16'hA044);

    // R12 request during busy is kept for the next boundary
    runSeq(16'h0000, 16'h0001, 16'h0002, 16'h0600, 1, 0, 0, 0, 0, 0, 1, 8'h55);
    check(gotIp == 16'hA000, "R12 running sequence unaffected", gotIp, 16'hA000);
    runSeq(16'h0000, 16'h0001, 16'h0002, 16'h0600, 0, 0, 0, 0, 0, 0, 0, 0);
    check(gotIp == 16'hA055, "R12 pending request serviced", gotIp, 16'hA055);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule